// File: doc/BRIEF.md
# Lane Write-Enable Mask Generator

This block turns a compact lane-enable encoding into a byte-granular write-enable mask for a 64-byte vector operand. A 3-bit mode picks the mask shape and a 6-bit value N sets its extent. The shapes are all lanes, odd or even lanes, a single lane, the first N lanes, the last N lanes, or no lanes. The mask is built for an element size of 1, 2 or 4 bytes. Only the lowest byte position of each enabled element is set, so a consumer that walks the vector in element steps can test one bit per element.

A select input routes the decoded mask to either the X or the Y operand, and the other operand gets an all-ones mask. Some encodings enable every lane and raise an override flag instead of masking: one flag forces the operation result to zero, and another forces the values of the masked operand to zero.

The block is combinational by default. A parameter adds one register stage on all outputs, and that stage clears under an active-low reset.

Top module: `lane_enable_mask`

## Requirements
- R1: Mode 0 with N=0, and modes 2 and 3 with N=0, enable every lane.
- R2: Mode 0 with N=1 enables only odd-indexed lanes. Mode 0 with N=2 enables only even-indexed lanes (lane 0 counts as even).
- R3: Mode 0 with N=3 enables every lane and raises `zeroResult`. Mode 0 with N=4 or N=5 enables every lane and raises the zero-operand flag of the masked operand. Mode 0 with N of 6 or more enables no lanes. In every other case both override flags stay low.
- R4: Mode 1 enables only lane N, and enables no lane when N is at least the lane count.
- R5: Modes 2 and 4 with N>0 enable lanes 0 to N-1, and enable all lanes when N is at least the lane count.
- R6: Modes 3 and 5 with N>0 enable the last N lanes, and enable all lanes when N is at least the lane count.
- R7: Modes 4 and 5 with N=0 enable no lanes.
- R8: Modes 6 and 7 enable no lanes, whatever N is.
- R9: `elemSize` 0 selects 1-byte elements, 1 selects 2-byte elements, and 2 or 3 select 4-byte elements. The lane count is 64 divided by the size. Lane k maps to mask bit k*size, and every other mask bit is 0.
- R10: When `applyY`=1 the decoded mask drives `yMask`, `xMask` is all ones, and the zero-operand flag appears on `zeroY`. When `applyY`=0 the roles of X and Y are swapped. `zeroX` and `zeroY` are never both high.
- R11: With `REG_OUT`=1, each output shows the decode of the inputs sampled at the previous rising clock edge. While `rstN` is low, both masks and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset for the output register |
| enMode | input | 3 | Enable mode |
| enValue | input | 6 | Mode value N |
| elemSize | input | 2 | Element size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| applyY | input | 1 | 1: mask applies to Y, 0: mask applies to X |
| xMask | output | 64 | Byte-lane enable mask for X |
| yMask | output | 64 | Byte-lane enable mask for Y |
| zeroResult | output | 1 | Force the operation result to zero |
| zeroX | output | 1 | Force X operand values to zero |
| zeroY | output | 1 | Force Y operand values to zero |

## Verification
Every mode is driven with N at 0, inside the lane range, at the last lane and past the lane count. This separates the all-on-zero modes from the none-on-zero modes and shows where first-N, last-N and single-lane saturate. Each pattern is repeated at all three element sizes, so a wrong lane-to-bit position or a missing alignment gate shows up as bits at the wrong offsets. Both values of the select input are used, which confirms that the mask and the zero-operand flag follow the selected operand. A registered instance is checked one edge late and under reset.

// File: rtl/lem_pkg.sv
package lem_pkg;

  // Lane-selection strobes from the decode to the mask builder.
  typedef struct packed {
    logic allLanes;
    logic oddLanes;
    logic evenLanes;
    logic oneLane;
    logic firstN;
    logic lastN;
    logic zeroRes;
    logic zeroOp;
  } lem_strobe_t;

  localparam lem_strobe_t STB_NONE = '0;

endpackage

// File: rtl/lem_control.sv
module lem_control
  import lem_pkg::*;
#(
  parameter int VAL_W = 6
) (
  input  logic [2:0]       enMode,
  input  logic [VAL_W-1:0] enValue,
  output lem_strobe_t      stb
);

  logic valIsZero;
  assign valIsZero = (enValue == '0);

  always_comb begin
    stb = STB_NONE;
    case (enMode)
      3'd0: begin
        if (enValue == VAL_W'(0)) stb.allLanes = 1'b1;
        else if (enValue == VAL_W'(1)) stb.oddLanes = 1'b1;
        else if (enValue == VAL_W'(2)) stb.evenLanes = 1'b1;
        else if (enValue == VAL_W'(3)) begin
          stb.allLanes = 1'b1;
          stb.zeroRes  = 1'b1;
        end else if (enValue == VAL_W'(4) || enValue == VAL_W'(5)) begin
          stb.allLanes = 1'b1;
          stb.zeroOp   = 1'b1;
        end
      end
      3'd1: stb.oneLane = 1'b1;
      3'd2: begin
        stb.allLanes = valIsZero;
        stb.firstN   = !valIsZero;
      end
      3'd3: begin
        stb.allLanes = valIsZero;
        stb.lastN    = !valIsZero;
      end
      3'd4: stb.firstN = 1'b1;
      3'd5: stb.lastN  = 1'b1;
      default: stb = STB_NONE;
    endcase
  end

endmodule

// File: rtl/lem_datapath.sv
module lem_datapath
  import lem_pkg::*;
#(
  parameter int NUM_BYTES = 64,
  parameter int VAL_W     = $clog2(NUM_BYTES)
) (
  input  lem_strobe_t          stb,
  input  logic [VAL_W-1:0]     enValue,
  input  logic [1:0]           elemSize,
  output logic [NUM_BYTES-1:0] laneMask
);

  localparam int IDX_W = VAL_W + 1;

  logic [1:0]       shiftAmt;
  logic [IDX_W-1:0] laneCount;
  logic [IDX_W-1:0] lowMask;
  logic [IDX_W-1:0] nWide;

  always_comb begin
    case (elemSize)
      2'd0:    shiftAmt = 2'd0;
      2'd1:    shiftAmt = 2'd1;
      default: shiftAmt = 2'd2;
    endcase
    laneCount = IDX_W'(NUM_BYTES) >> shiftAmt;
    lowMask   = (IDX_W'(1) << shiftAmt) - IDX_W'(1);
    nWide     = {1'b0, enValue};
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [IDX_W-1:0] bytePos;
    logic [IDX_W-1:0] lane;
    logic             aligned;
    logic             laneOn;
    always_comb begin
      bytePos = IDX_W'(b);
      lane    = bytePos >> shiftAmt;
      aligned = ((bytePos & lowMask) == '0);
      laneOn  = stb.allLanes
              | (stb.oddLanes  &  lane[0])
              | (stb.evenLanes & ~lane[0])
              | (stb.oneLane   & (lane == nWide))
              | (stb.firstN    & (lane < nWide))
              | (stb.lastN     & ((lane + nWide) >= laneCount));
      laneMask[b] = aligned & laneOn;
    end
  end

endmodule

// File: rtl/lane_enable_mask.sv
module lane_enable_mask
  import lem_pkg::*;
#(
  parameter int NUM_BYTES = 64,
  parameter int VAL_W     = $clog2(NUM_BYTES),
  parameter bit REG_OUT   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           enMode,
  input  logic [VAL_W-1:0]     enValue,
  input  logic [1:0]           elemSize,
  input  logic                 applyY,
  output logic [NUM_BYTES-1:0] xMask,
  output logic [NUM_BYTES-1:0] yMask,
  output logic                 zeroResult,
  output logic                 zeroX,
  output logic                 zeroY
);

  lem_strobe_t          stb;
  logic [NUM_BYTES-1:0] laneMask;
  logic [NUM_BYTES-1:0] combX, combY;
  logic                 combZr, combZx, combZy;

  lem_control #(.VAL_W(VAL_W)) u_ctrl (
    .enMode  (enMode),
    .enValue (enValue),
    .stb     (stb)
  );

  lem_datapath #(.NUM_BYTES(NUM_BYTES), .VAL_W(VAL_W)) u_dp (
    .stb      (stb),
    .enValue  (enValue),
    .elemSize (elemSize),
    .laneMask (laneMask)
  );

  always_comb begin
    combX  = applyY ? '1 : laneMask;
    combY  = applyY ? laneMask : '1;
    combZr = stb.zeroRes;
    combZx = stb.zeroOp & ~applyY;
    combZy = stb.zeroOp &  applyY;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        xMask      <= '0;
        yMask      <= '0;
        zeroResult <= 1'b0;
        zeroX      <= 1'b0;
        zeroY      <= 1'b0;
      end else begin
        xMask      <= combX;
        yMask      <= combY;
        zeroResult <= combZr;
        zeroX      <= combZx;
        zeroY      <= combZy;
      end
    end

    assert_reg_delay_R11: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (xMask == $past(combX) && yMask == $past(combY) && zeroResult == $past(combZr)));
  end else begin : g_comb
    assign xMask      = combX;
    assign yMask      = combY;
    assign zeroResult = combZr;
    assign zeroX      = combZx;
    assign zeroY      = combZy;
  end

  // Checks on the decoded path, sampled at the clock edge.
  assert_none_modes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enMode[2:1] == 2'b11) |-> (laneMask == '0));

  assert_zero_n_all_R1: assert property (@(posedge clk) disable iff (!rstN)
    (enMode == 3'd2 && enValue == '0 && elemSize == 2'd0) |-> ($countones(laneMask) == NUM_BYTES));

  assert_zero_res_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    combZr |-> (enMode == 3'd0 && enValue == VAL_W'(3)));

  assert_single_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enMode == 3'd1) |-> $onehot0(laneMask));

  assert_zero_n_none_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enMode[2:1] == 2'b10 && enValue == '0) |-> (laneMask == '0));

  assert_other_ones_R10: assert property (@(posedge clk) disable iff (!rstN)
    (applyY ? (combX == '1) : (combY == '1)) && !(combZx && combZy));

endmodule

// File: tb/lane_enable_mask_test.sv
module lane_enable_mask_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  enMode = '0;
  logic [5:0]  enValue = '0;
  logic [1:0]  elemSize = '0;
  logic        applyY = 1'b0;
  logic [63:0] xMask, yMask, rxMask, ryMask;
  logic        zeroResult, zeroX, zeroY, rZr, rZx, rZy;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lane_enable_mask uut (
    .clk(clk), .rstN(rstN), .enMode(enMode), .enValue(enValue),
    .elemSize(elemSize), .applyY(applyY), .xMask(xMask), .yMask(yMask),
    .zeroResult(zeroResult), .zeroX(zeroX), .zeroY(zeroY)
  );

  lane_enable_mask #(.REG_OUT(1'b1)) uutReg (
    .clk(clk), .rstN(rstN), .enMode(enMode), .enValue(enValue),
    .elemSize(elemSize), .applyY(applyY), .xMask(rxMask), .yMask(ryMask),
    .zeroResult(rZr), .zeroX(rZx), .zeroY(rZy)
  );

  // Reference mask built from the requirement text.
  function automatic logic [63:0] refMask(int mode, int n, int es);
    int sz = (es == 0) ? 1 : (es == 1) ? 2 : 4;
    int lanes = 64 / sz;
    logic [63:0] m = '0;
    for (int k = 0; k < lanes; k++) begin
      bit on = 0;
      case (mode)
        0: on = (n == 0) || (n == 3) || (n == 4) || (n == 5) ||
                (n == 1 && (k % 2) == 1) || (n == 2 && (k % 2) == 0);
        1: on = (k == n);
        2: on = (n == 0) || (k < n);
        3: on = (n == 0) || (k >= lanes - n);
        4: on = (k < n);
        5: on = (n > 0) && (k >= lanes - n);
        default: on = 0;
      endcase
      if (on) m[k*sz] = 1'b1;
    end
    return m;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(int mode, int n, int es, bit selY);
    enMode = 3'(mode);
    enValue = 6'(n);
    elemSize = 2'(es);
    applyY = selY;
  endtask

  // Drive at a falling edge and check the combinational instance.
  task automatic run(string tag, int mode, int n, int es, bit selY);
    logic [63:0] m;
    bit zr, zo;
    @(negedge clk);
    drive(mode, n, es, selY);
    #1;
    m  = refMask(mode, n, es);
    zr = (mode == 0 && n == 3);
    zo = (mode == 0 && (n == 4 || n == 5));
    chk({tag, " xMask"}, xMask, selY ? '1 : m);
    chk({tag, " yMask"}, yMask, selY ? m : '1);
    chk({tag, " flags R3"}, {61'd0, zeroResult, zeroX, zeroY},
        {61'd0, zr, zo && !selY, zo && selY});
  endtask

  task automatic test_reset();
    @(negedge clk);
    drive(0, 0, 0, 0);
    @(posedge clk); #1;
    chk("R11 reset xMask", rxMask, '0);
    chk("R11 reset yMask", ryMask, '0);
    chk("R11 reset flags", {61'd0, rZr, rZx, rZy}, '0);
  endtask

  task automatic test_mode0();
    for (int es = 0; es < 3; es++) begin
      run("R1 mode0 n0", 0, 0, es, 0);
      run("R2 odd", 0, 1, es, 0);
      run("R2 even", 0, 2, es, 1);
      run("R3 zero result", 0, 3, es, 0);
      run("R3 zero op n4", 0, 4, es, 0);
      run("R3 zero op n5", 0, 5, es, 1);
      run("R3 none n6", 0, 6, es, 0);
      run("R3 none n63", 0, 63, es, 1);
    end
  endtask

  task automatic test_single();
    run("R4 lane0", 1, 0, 0, 0);
    run("R4 lane63", 1, 63, 0, 1);
    run("R4 lane15 es2", 1, 15, 2, 0);
    run("R4 past count es2", 1, 16, 2, 0);
    run("R4 past count es1", 1, 40, 1, 1);
  endtask

  task automatic test_first_last();
    for (int es = 0; es < 3; es++) begin
      run("R1 first n0", 2, 0, es, 0);
      run("R1 last n0", 3, 0, es, 1);
      run("R5 first n5", 2, 5, es, 0);
      run("R5 first n5 m4", 4, 5, es, 1);
      run("R5 first sat", 4, 40, es, 0);
      run("R6 last n3", 3, 3, es, 0);
      run("R6 last n7 m5", 5, 7, es, 1);
      run("R6 last sat", 5, 63, es, 0);
      run("R7 first n0", 4, 0, es, 0);
      run("R7 last n0", 5, 0, es, 1);
    end
  endtask

  task automatic test_none();
    run("R8 mode6", 6, 0, 0, 0);
    run("R8 mode7", 7, 9, 1, 1);
    run("R8 mode6 n4", 6, 4, 2, 0);
  endtask

  task automatic test_elem_size();
    run("R9 size code3", 2, 0, 3, 0);
    run("R9 size code3 odd", 0, 1, 3, 1);
    run("R9 size1 last2", 3, 2, 1, 0);
  endtask

  task automatic test_select();
    run("R10 selX", 4, 10, 0, 0);
    run("R10 selY", 4, 10, 0, 1);
    run("R10 zeroY", 0, 4, 1, 1);
    run("R10 zeroX", 0, 4, 1, 0);
  endtask

  task automatic test_registered();
    logic [63:0] prev;
    @(negedge clk);
    drive(2, 4, 0, 1);
    @(posedge clk); #1;
    prev = refMask(2, 4, 0);
    chk("R11 reg yMask", ryMask, prev);
    chk("R11 reg xMask", rxMask, '1);
    @(negedge clk);
    drive(0, 3, 1, 0);
    #1;
    chk("R11 holds before edge", ryMask, prev);
    @(posedge clk); #1;
    chk("R11 reg after edge x", rxMask, refMask(0, 3, 1));
    chk("R11 reg zeroResult", {63'd0, rZr}, 64'd1);
  endtask

  bit done = 0;

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    test_reset();
    @(negedge clk);
    rstN = 1'b1;
    test_mode0();
    test_single();
    test_first_last();
    test_none();
    test_elem_size();
    test_select();
    test_registered();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule